// File: doc/BRIEF.md
# PCI Single-Beat Initiator Sequencer

This block carries out one PCI bus transaction with exactly one data phase for a requester on the processor side. The requester presents a target address, a bus command, active-low byte enables, a direction flag and, for a write, one word of data. It holds `reqValid` high until it sees `done`. Once the block owns the bus, it drives the address clock. It then ends the frame and opens the data phase in the same clock, waits for the target to claim the cycle and signal ready, and finishes with a one-clock `done` pulse. For a read, the captured word on `rdData` is valid in that same clock.

The shared address/data bus and the command/byte-enable lines are modelled as separate in and out vectors with output enables, so the block fits a pad ring or a bus model. Arbitration is reduced to a `grant` input. The block also watches the sampled bus `frame#` and `irdy#`, so it never starts while another master's transaction is still in flight. Parity, bursts, target behaviour and abort handling are not part of this block.

Top module: `pciSingleInit`

## Requirements
- R1: In the first clock after a request is accepted, `frameN` is low, `irdyN` is high, `ctrlOe` and `adOe` are high, `adOut` carries the request address and `cbeN` carries the 4-bit command.
- R2: In the next clock, `frameN` returns high and `irdyN` goes low together, and `cbeN` switches to the request's active-low byte enables. `frameN` and `irdyN` are never low in the same clock.
- R3: For a read (`reqWrite`=0), `adOe` is low from the clock in which `irdyN` first goes low until the transaction ends.
- R4: For a write (`reqWrite`=1), `adOut` carries the write data with `adOe` high from the same clock in which `irdyN` first goes low.
- R5: The data phase completes only at a rising edge where `devselN` and `trdyN` are both sampled low. Until then `irdyN` stays low and `done` stays low, including while `trdyN` is low with `devselN` high.
- R6: For a read, the word on `adIn` at the completing edge appears on `rdData`. In the clock that follows, `done` is high and `irdyN` is high.
- R7: For a write, `irdyN` goes high after the completing edge, but `adOut` and `adOe` keep the data for as long as `trdyN` is sampled low. At the first edge that samples `trdyN` high, `adOe` drops and `done` pulses.
- R8: `done` is high for exactly one clock. In the clock after it, `ctrlOe` is low and both `frameN` and `irdyN` are high.
- R9: A request is accepted only at an edge where the block is idle, `reqValid` and `grant` are high, and the sampled `busFrameN` and `busIrdyN` are both high. Otherwise `frameN` stays high.
- R10: After reset, `frameN` and `irdyN` are high and `ctrlOe`, `adOe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until `done` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADW | Target address |
| reqCmd | input | 4 | Bus command for the address clock |
| reqBe | input | ADW/8 | Active-low byte enables for the data clock |
| reqWdata | input | ADW | Write data |
| rdData | output | ADW | Read data, valid while `done` is high |
| done | output | 1 | One-clock completion pulse |
| grant | input | 1 | Bus granted to this initiator |
| busFrameN | input | 1 | Sampled bus frame#, active low |
| busIrdyN | input | 1 | Sampled bus irdy#, active low |
| devselN | input | 1 | Target claim, active low |
| trdyN | input | 1 | Target ready, active low |
| adIn | input | ADW | Address/data bus as received |
| adOut | output | ADW | Address/data bus value to drive |
| adOe | output | 1 | Output enable for `adOut` |
| cbeN | output | 4 | Command or byte enables to drive |
| frameN | output | 1 | frame#, active low |
| irdyN | output | 1 | irdy#, active low |
| ctrlOe | output | 1 | Output enable for `frameN`, `irdyN`, `cbeN` |

## Verification
The address clock is visible one edge after acceptance, and the data clock one edge after that. A read's `done` and `rdData` appear one edge after the edge that first samples both `devselN` and `trdyN` low. A write's `done` appears one edge after `trdyN` is first sampled high again. The release of `ctrlOe` follows `done` by exactly one edge. The bench changes inputs on falling edges and compares outputs at the following falling edge, so each expected value is checked in the one clock the count above predicts. It sweeps direction, the number of wait clocks, early `trdyN` without `devselN`, and the number of write hold clocks.

// File: rtl/pciSeqPkg.sv
package pciSeqPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_HOLD,
    ST_END
  } seqState_t;

  typedef struct packed {
    logic latchReq;   // take request fields, drive address clock
    logic enterData;  // switch to data clock
    logic captureRd;  // sample the bus into read data
    logic dropAd;     // stop driving the write data
  } dpStrobe_t;
endpackage

// File: rtl/pciSeqCtrl.sv
module pciSeqCtrl
  import pciSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      grant,
  input  logic      busFrameN,
  input  logic      busIrdyN,
  input  logic      devselN,
  input  logic      trdyN,
  output logic      frameN,
  output logic      irdyN,
  output logic      ctrlOe,
  output logic      done,
  output dpStrobe_t strobe
);
  seqState_t state, nxt;
  logic      isWr;
  logic      canStart;

  assign canStart = reqValid && grant && busFrameN && busIrdyN;

  always_comb begin
    nxt    = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: if (canStart) begin
        nxt             = ST_ADDR;
        strobe.latchReq = 1'b1;
      end
      ST_ADDR: begin
        nxt              = ST_DATA;
        strobe.enterData = 1'b1;
      end
      ST_DATA: if (!devselN && !trdyN) begin
        nxt              = isWr ? ST_HOLD : ST_END;
        strobe.captureRd = !isWr;
      end
      ST_HOLD: if (trdyN) begin
        nxt           = ST_END;
        strobe.dropAd = 1'b1;
      end
      ST_END:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      frameN <= 1'b1;
      irdyN  <= 1'b1;
      ctrlOe <= 1'b0;
      done   <= 1'b0;
      isWr   <= 1'b0;
    end else begin
      state  <= nxt;
      frameN <= (nxt != ST_ADDR);
      irdyN  <= (nxt != ST_DATA);
      ctrlOe <= (nxt != ST_IDLE);
      done   <= (nxt == ST_END) && (state != ST_END);
      if (strobe.latchReq) isWr <= reqWrite;
    end
  end

  AST_NO_DUAL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !(!frameN && !irdyN)); // R2
  AST_FRAME_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> frameN); // R1
  AST_FRAME_TO_IRDY: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !irdyN); // R2
  AST_WAIT_FOR_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (!irdyN && devselN) |=> (!irdyN && !done)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !ctrlOe)); // R8
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && (!grant || !busFrameN || !busIrdyN)) |=> frameN); // R9
endmodule

// File: rtl/pciSeqDp.sv
module pciSeqDp
  import pciSeqPkg::*;
#(
  parameter int ADW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             reqWrite,
  input  logic [ADW-1:0]   reqAddr,
  input  logic [3:0]       reqCmd,
  input  logic [ADW/8-1:0] reqBe,
  input  logic [ADW-1:0]   reqWdata,
  input  logic [ADW-1:0]   adIn,
  output logic [ADW-1:0]   adOut,
  output logic             adOe,
  output logic [3:0]       cbeN,
  output logic [ADW-1:0]   rdData
);
  localparam int BEW = ADW / 8;

  logic [BEW-1:0] beQ;
  logic [ADW-1:0] wdQ;
  logic           wrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adOut  <= '0;
      adOe   <= 1'b0;
      cbeN   <= '1;
      rdData <= '0;
      beQ    <= '1;
      wdQ    <= '0;
      wrQ    <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        adOut <= reqAddr;
        adOe  <= 1'b1;
        cbeN  <= reqCmd;
        beQ   <= reqBe;
        wdQ   <= reqWdata;
        wrQ   <= reqWrite;
      end
      if (strobe.enterData) begin
        cbeN <= beQ[3:0];
        adOe <= wrQ;
        if (wrQ) adOut <= wdQ;
      end
      if (strobe.captureRd) rdData <= adIn;
      if (strobe.dropAd)    adOe   <= 1'b0;
    end
  end

  AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enterData && !wrQ) |=> !adOe); // R3
endmodule

// File: rtl/pciSingleInit.sv
module pciSingleInit
  import pciSeqPkg::*;
#(
  parameter int ADW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [ADW-1:0]   reqAddr,
  input  logic [3:0]       reqCmd,
  input  logic [ADW/8-1:0] reqBe,
  input  logic [ADW-1:0]   reqWdata,
  output logic [ADW-1:0]   rdData,
  output logic             done,
  input  logic             grant,
  input  logic             busFrameN,
  input  logic             busIrdyN,
  input  logic             devselN,
  input  logic             trdyN,
  input  logic [ADW-1:0]   adIn,
  output logic [ADW-1:0]   adOut,
  output logic             adOe,
  output logic [3:0]       cbeN,
  output logic             frameN,
  output logic             irdyN,
  output logic             ctrlOe
);
  dpStrobe_t strobe;

  pciSeqCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .grant     (grant),
    .busFrameN (busFrameN),
    .busIrdyN  (busIrdyN),
    .devselN   (devselN),
    .trdyN     (trdyN),
    .frameN    (frameN),
    .irdyN     (irdyN),
    .ctrlOe    (ctrlOe),
    .done      (done),
    .strobe    (strobe)
  );

  pciSeqDp #(.ADW(ADW)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqCmd   (reqCmd),
    .reqBe    (reqBe),
    .reqWdata (reqWdata),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .cbeN     (cbeN),
    .rdData   (rdData)
  );

  AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> (adOe && ctrlOe)); // R1
  AST_WRITE_DATA_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!irdyN && adOe) |=> adOe); // R7
endmodule

// File: tb/test_pciSingleInit.sv
module test_pciSingleInit;
  localparam int ADW = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADW-1:0] reqAddr = '0, reqWdata = '0, adIn = '0;
  logic [3:0]     reqCmd = '0, reqBe = '1;
  logic [ADW-1:0] rdData, adOut;
  logic           done, adOe, frameN, irdyN, ctrlOe;
  logic [3:0]     cbeN;
  logic           grant = 1'b0, busFrameN = 1'b1, busIrdyN = 1'b1;
  logic           devselN = 1'b1, trdyN = 1'b1;

  int runs = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pciSingleInit #(.ADW(ADW)) i_pciSingleInit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqCmd(reqCmd), .reqBe(reqBe), .reqWdata(reqWdata),
    .rdData(rdData), .done(done), .grant(grant), .busFrameN(busFrameN),
    .busIrdyN(busIrdyN), .devselN(devselN), .trdyN(trdyN), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .cbeN(cbeN), .frameN(frameN),
    .irdyN(irdyN), .ctrlOe(ctrlOe)
  );

  task automatic chk(input string req, input logic [ADW-1:0] act, input logic [ADW-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      runs++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  // One full transaction; inputs change on falling edges, outputs checked there.
  task automatic runTxn(input bit wr, input logic [ADW-1:0] addr, input logic [3:0] cmd,
                        input logic [3:0] be, input logic [ADW-1:0] data,
                        input int waits, input bit earlyTrdy, input int holds);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqCmd = cmd; reqBe = be;
    reqWdata = wr ? data : ~data; grant = 1; busFrameN = 1; busIrdyN = 1;
    devselN = 1; trdyN = 1; adIn = '0;
    @(negedge clk);
    chk("R1 frameN", frameN, 0);     chk("R1 irdyN", irdyN, 1);
    chk("R1 adOe", adOe, 1);         chk("R1 ctrlOe", ctrlOe, 1);
    chk("R1 ad", adOut, addr);       chk("R1 cbe", cbeN, cmd);
    @(negedge clk);
    chk("R2 frameN", frameN, 1);     chk("R2 irdyN", irdyN, 0);
    chk("R2 cbe", cbeN, be);
    if (wr) begin
      chk("R4 adOe", adOe, 1);       chk("R4 ad", adOut, data);
    end else chk("R3 adOe", adOe, 0);
    for (int i = 0; i < waits; i++) begin
      if (earlyTrdy) trdyN = 0;
      @(negedge clk);
      chk("R5 irdyN", irdyN, 0);     chk("R5 done", done, 0);
      if (!wr) chk("R3 adOe wait", adOe, 0);
    end
    devselN = 0; trdyN = 0; adIn = data;
    @(negedge clk);
    adIn = '0;
    if (!wr) begin
      chk("R6 done", done, 1);       chk("R6 rdData", rdData, data);
      chk("R6 irdyN", irdyN, 1);     chk("R3 adOe end", adOe, 0);
    end else begin
      chk("R7 done", done, 0);       chk("R7 irdyN", irdyN, 1);
      chk("R7 adOe", adOe, 1);       chk("R7 ad", adOut, data);
      for (int h = 0; h < holds; h++) begin
        @(negedge clk);
        chk("R7 hold adOe", adOe, 1); chk("R7 hold ad", adOut, data);
        chk("R7 hold done", done, 0);
      end
      devselN = 1; trdyN = 1;
      @(negedge clk);
      chk("R7 release done", done, 1); chk("R7 release adOe", adOe, 0);
    end
    reqValid = 0; devselN = 1; trdyN = 1;
    @(negedge clk);
    chk("R8 done", done, 0);         chk("R8 ctrlOe", ctrlOe, 0);
    chk("R8 frameN", frameN, 1);     chk("R8 irdyN", irdyN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 frameN", frameN, 1);    chk("R10 irdyN", irdyN, 1);
    chk("R10 ctrlOe", ctrlOe, 0);    chk("R10 adOe", adOe, 0);
    chk("R10 done", done, 0);
    rstN = 1;
    @(negedge clk);

    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 3; p++) begin
          logic [ADW-1:0] a, v;
          a = 32'h1000_0000 + (p << 8) + w * 4;
          v = (a * 32'h9E37_79B9) ^ (d ? 32'hA5A5_5A5A : 32'h0F0F_F0F0);
          runTxn(d[0], a, d ? 4'h7 : 4'h6, ~(4'h1 << p), v, w, w[0], w);
        end

    // Hold-off: no grant, then bus busy with frame#, then with irdy#.
    reqValid = 1; reqWrite = 0; grant = 0; busFrameN = 1; busIrdyN = 1;
    repeat (2) begin @(negedge clk); chk("R9 no grant", frameN, 1); end
    grant = 1; busFrameN = 0;
    repeat (2) begin @(negedge clk); chk("R9 bus frame busy", frameN, 1); end
    busFrameN = 1; busIrdyN = 0;
    repeat (2) begin @(negedge clk); chk("R9 bus irdy busy", frameN, 1); end
    runTxn(1'b0, 32'hCAFE_0040, 4'h6, 4'h0, 32'h1234_5678, 2, 1'b1, 0);
    runTxn(1'b1, 32'hCAFE_0080, 4'h7, 4'hC, 32'h8765_4321, 0, 1'b0, 0);

    finishRun();
  end
endmodule